// File: doc/BRIEF.md
# Floating-point opcode decoder

This block decodes the register-to-register floating-point instruction group of a RISC-style core. It reads five fields: the 7-bit function field, the 3-bit rounding-mode field, the rs2 field, the destination index, and the dynamic rounding mode that the core holds in its floating-point control state. From these it produces a single operation code, the operand precision, and the rounding mode that applies. It also produces the register file that receives the result, a write enable, a strobe that marks the floating-point state dirty, and an illegal-instruction flag.

The function field holds an operation in bits 6:2 and a precision in bits 1:0. For some operations the rm field picks the variant. For others rs2 picks it, and for the remaining ones rm is a rounding mode. The decoder applies the legality rules of each operation and routes the write to the correct register file. It also resolves the dynamic rounding mode. The integer register width `XLEN` is a parameter. It controls whether 64-bit integer conversions are legal and whether raw bit moves are legal for each precision.

All decode results are registered. A set of inputs present at one rising clock edge appears on the outputs after that edge.

Top module: `fp_op_decoder`

## Requirements
- R1: Function bits 1:0 select the precision: 0 is single (32 bits), 1 is double (64 bits), 3 is quad (128 bits). Value 2 is illegal. `fmt_o` always echoes bits 1:0.
- R2: Function bits 6:2 select the operation. The legal values are 0x00 add, 0x01 subtract, 0x02 multiply, 0x03 divide, 0x04 sign-inject, 0x05 min/max, 0x08 float-to-float convert, 0x0b square root, 0x14 compare, 0x18 float-to-integer, 0x1a integer-to-float, 0x1c move-to-integer/classify and 0x1e move-from-integer. Every other value is illegal.
- R3: For add, subtract, multiply, divide, square root and the three conversions, rm is a rounding mode. Values 0 to 4 pass through to `rm_o`. Values 5 and 6 are illegal. Value 7 takes the dynamic mode, which is illegal if it is 5, 6 or 7. For every other operation `rm_o` is 0.
- R4: Square root is illegal unless rs2 is 0.
- R5: For sign-inject, rm 0/1/2 select plain, negated and xor. For min/max, rm 0 is min and rm 1 is max. For compare, rm 0 is less-or-equal, 1 is less-than and 2 is equal. Any other rm is illegal for these three operations.
- R6: For float-to-integer and integer-to-float, rs2 selects the integer type: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. Values 2 and 3 need XLEN of at least 64. Values above 3 are illegal.
- R7: Float-to-float convert is legal only in two forms: single target with rs2=1 (double source), or double target with rs2=0 (single source).
- R8: Move-to-integer/classify needs rs2=0. With rm 0 it is a raw move, legal only if the precision width is no wider than XLEN. With rm 1 it is classify. Move-from-integer needs rs2=0 and rm=0, and the precision width no wider than XLEN.
- R9: Compare, float-to-integer and move-to-integer/classify set `dst_int_o`. For these operations `wen_o` is low when rd is 0.
- R10: Every legal operation that writes a floating-point register raises both `wen_o` and `fs_dirty_o`, whatever the value of rd.
- R11: When `illegal_o` is high, `op_o`, `rm_o`, `dst_int_o`, `wen_o` and `fs_dirty_o` are all 0.
- R12: Outputs are registered with one cycle of latency. During reset `illegal_o`, `wen_o`, `fs_dirty_o`, `dst_int_o`, `rm_o` and `op_o` read 0.
- R13: Encoding of `op_o`:
  - 0: none
  - 1: add; 2: sub; 3: mul; 4: div; 5: sqrt
  - 6: sign-inject plain; 7: sign-inject negated; 8: sign-inject xor
  - 9: min; 10: max
  - 11: le; 12: lt; 13: eq
  - 14 to 17: float-to-int signed32, unsigned32, signed64, unsigned64
  - 18 to 21: int-to-float in the same type order
  - 22: to-single-from-double; 23: to-double-from-single
  - 24: move-to-int; 25: classify; 26: move-from-int

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| funct7_i | input | 7 | Operation (6:2) and precision (1:0) |
| rm_i | input | 3 | Rounding-mode / variant field |
| rs2_i | input | 5 | Second source field, used as a sub-selector |
| rd_i | input | 5 | Destination register index |
| dyn_rm_i | input | 3 | Dynamic rounding mode from control state |
| op_o | output | 5 | Decoded operation (R13) |
| fmt_o | output | 2 | Precision field echo |
| rm_o | output | 3 | Resolved rounding mode |
| dst_int_o | output | 1 | Result goes to the integer register file |
| wen_o | output | 1 | Register write enable |
| fs_dirty_o | output | 1 | Mark floating-point state dirty |
| illegal_o | output | 1 | Illegal encoding |

## Verification
Some properties must hold on every cycle, and the assertions check these. Illegal encodings never carry a write, a dirty strobe or an operation code. A dirty strobe always comes with a floating-point write. An integer write never targets index 0. A resolved rounding mode is always in the range 0 to 4. The assertions also check two registered cause-and-effect relations: a reserved precision one cycle earlier produces illegal, and a reserved rounding mode on add one cycle earlier produces illegal. The variant mapping of each operation can only be shown by the bench's scenarios. The same holds for the rs2 and rm legality tables, the dynamic-mode substitution, and the width-dependent rules for 32-bit and 64-bit integer registers.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    // Operation field values (function bits 6:2)
    localparam logic [4:0] OPF_ADD    = 5'h00;
    localparam logic [4:0] OPF_SUB    = 5'h01;
    localparam logic [4:0] OPF_MUL    = 5'h02;
    localparam logic [4:0] OPF_DIV    = 5'h03;
    localparam logic [4:0] OPF_SGNJ   = 5'h04;
    localparam logic [4:0] OPF_MINMAX = 5'h05;
    localparam logic [4:0] OPF_F2F    = 5'h08;
    localparam logic [4:0] OPF_SQRT   = 5'h0b;
    localparam logic [4:0] OPF_CMP    = 5'h14;
    localparam logic [4:0] OPF_F2I    = 5'h18;
    localparam logic [4:0] OPF_I2F    = 5'h1a;
    localparam logic [4:0] OPF_MVX    = 5'h1c;
    localparam logic [4:0] OPF_MVF    = 5'h1e;

    localparam logic [1:0] FMT_S = 2'd0;
    localparam logic [1:0] FMT_D = 2'd1;
    localparam logic [1:0] FMT_Q = 2'd3;

    // Decoded operation codes (R13)
    typedef enum logic [4:0] {
        OP_NONE     = 5'd0,
        OP_ADD      = 5'd1,
        OP_SUB      = 5'd2,
        OP_MUL      = 5'd3,
        OP_DIV      = 5'd4,
        OP_SQRT     = 5'd5,
        OP_SGN_PL   = 5'd6,
        OP_SGN_NEG  = 5'd7,
        OP_SGN_XOR  = 5'd8,
        OP_MIN      = 5'd9,
        OP_MAX      = 5'd10,
        OP_LE       = 5'd11,
        OP_LT       = 5'd12,
        OP_EQ       = 5'd13,
        OP_F2I_S32  = 5'd14,
        OP_F2I_U32  = 5'd15,
        OP_F2I_S64  = 5'd16,
        OP_F2I_U64  = 5'd17,
        OP_I2F_S32  = 5'd18,
        OP_I2F_U32  = 5'd19,
        OP_I2F_S64  = 5'd20,
        OP_I2F_U64  = 5'd21,
        OP_TO_S     = 5'd22,
        OP_TO_D     = 5'd23,
        OP_MV_TOINT = 5'd24,
        OP_CLASS    = 5'd25,
        OP_MV_FRINT = 5'd26
    } fp_op_e;

    typedef struct packed {
        fp_op_e     op;
        logic [1:0] fmt;
        logic [2:0] rm;
        logic       to_int;
        logic       wen;
        logic       dirty;
        logic       illegal;
    } dec_out_t;

endpackage

// File: rtl/fpdec_rm_resolve.sv
module fpdec_rm_resolve (
    input  logic [2:0] rm_field_i,
    input  logic [2:0] dyn_rm_i,
    output logic [2:0] rm_eff_o,
    output logic       rm_bad_o
);
    localparam logic [2:0] RM_DYN      = 3'd7;
    localparam logic [2:0] RM_LAST_OK  = 3'd4;

    always_comb begin
        rm_eff_o = (rm_field_i == RM_DYN) ? dyn_rm_i : rm_field_i;
        rm_bad_o = (rm_eff_o > RM_LAST_OK);
        if (rm_bad_o) begin
            rm_eff_o = 3'd0;
        end
    end
endmodule

// File: rtl/fpdec_int_sel.sv
module fpdec_int_sel #(
    parameter int XLEN = 64
) (
    input  logic [4:0] sel_i,
    output logic [1:0] kind_o,
    output logic       bad_o
);
    localparam int  MAX_SEL  = (XLEN >= 64) ? 3 : 1;

    assign kind_o = sel_i[1:0];

    generate
        if (MAX_SEL == 3) begin : g_wide
            assign bad_o = (sel_i > 5'd3);
        end else begin : g_narrow
            assign bad_o = (sel_i > 5'd1);
        end
    endgenerate
endmodule

// File: rtl/fpdec_fit_chk.sv
module fpdec_fit_chk #(
    parameter int XLEN = 64
) (
    input  logic [1:0] fmt_i,
    output logic       fits_o
);
    import fpdec_pkg::*;

    localparam bit FIT_S = (XLEN >= 32);
    localparam bit FIT_D = (XLEN >= 64);
    localparam bit FIT_Q = (XLEN >= 128);

    always_comb begin
        case (fmt_i)
            FMT_S:   fits_o = FIT_S;
            FMT_D:   fits_o = FIT_D;
            FMT_Q:   fits_o = FIT_Q;
            default: fits_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_op_decoder.sv
module fp_op_decoder #(
    parameter int XLEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] funct7_i,
    input  logic [2:0] rm_i,
    input  logic [4:0] rs2_i,
    input  logic [4:0] rd_i,
    input  logic [2:0] dyn_rm_i,
    output logic [4:0] op_o,
    output logic [1:0] fmt_o,
    output logic [2:0] rm_o,
    output logic       dst_int_o,
    output logic       wen_o,
    output logic       fs_dirty_o,
    output logic       illegal_o
);
    import fpdec_pkg::*;

    logic [4:0] opf;
    logic [1:0] fmt;
    logic [2:0] rm_eff;
    logic       rm_bad;
    logic [1:0] int_kind;
    logic       int_bad;
    logic       fits;

    assign opf = funct7_i[6:2];
    assign fmt = funct7_i[1:0];

    fpdec_rm_resolve u_rm (
        .rm_field_i (rm_i),
        .dyn_rm_i   (dyn_rm_i),
        .rm_eff_o   (rm_eff),
        .rm_bad_o   (rm_bad)
    );

    fpdec_int_sel #(.XLEN(XLEN)) u_isel (
        .sel_i  (rs2_i),
        .kind_o (int_kind),
        .bad_o  (int_bad)
    );

    fpdec_fit_chk #(.XLEN(XLEN)) u_fit (
        .fmt_i  (fmt),
        .fits_o (fits)
    );

    dec_out_t dec_d, dec_q;

    always_comb begin
        logic   ill;
        logic   use_rnd;
        logic   to_int;
        logic   fp_wr;
        fp_op_e op;

        ill     = 1'b0;
        use_rnd = 1'b0;
        to_int  = 1'b0;
        fp_wr   = 1'b0;
        op      = OP_NONE;

        case (opf)
            OPF_ADD: begin op = OP_ADD; use_rnd = 1'b1; fp_wr = 1'b1; end
            OPF_SUB: begin op = OP_SUB; use_rnd = 1'b1; fp_wr = 1'b1; end
            OPF_MUL: begin op = OP_MUL; use_rnd = 1'b1; fp_wr = 1'b1; end
            OPF_DIV: begin op = OP_DIV; use_rnd = 1'b1; fp_wr = 1'b1; end
            OPF_SQRT: begin
                op      = OP_SQRT;
                use_rnd = 1'b1;
                fp_wr   = 1'b1;
                if (rs2_i != 5'd0) ill = 1'b1;
            end
            OPF_SGNJ: begin
                fp_wr = 1'b1;
                case (rm_i)
                    3'd0:    op = OP_SGN_PL;
                    3'd1:    op = OP_SGN_NEG;
                    3'd2:    op = OP_SGN_XOR;
                    default: ill = 1'b1;
                endcase
            end
            OPF_MINMAX: begin
                fp_wr = 1'b1;
                case (rm_i)
                    3'd0:    op = OP_MIN;
                    3'd1:    op = OP_MAX;
                    default: ill = 1'b1;
                endcase
            end
            OPF_CMP: begin
                to_int = 1'b1;
                case (rm_i)
                    3'd0:    op = OP_LE;
                    3'd1:    op = OP_LT;
                    3'd2:    op = OP_EQ;
                    default: ill = 1'b1;
                endcase
            end
            OPF_F2I: begin
                to_int  = 1'b1;
                use_rnd = 1'b1;
                if (int_bad) ill = 1'b1;
                case (int_kind)
                    2'd0:    op = OP_F2I_S32;
                    2'd1:    op = OP_F2I_U32;
                    2'd2:    op = OP_F2I_S64;
                    default: op = OP_F2I_U64;
                endcase
            end
            OPF_I2F: begin
                fp_wr   = 1'b1;
                use_rnd = 1'b1;
                if (int_bad) ill = 1'b1;
                case (int_kind)
                    2'd0:    op = OP_I2F_S32;
                    2'd1:    op = OP_I2F_U32;
                    2'd2:    op = OP_I2F_S64;
                    default: op = OP_I2F_U64;
                endcase
            end
            OPF_F2F: begin
                fp_wr   = 1'b1;
                use_rnd = 1'b1;
                if (fmt == FMT_S && rs2_i == 5'd1) begin
                    op = OP_TO_S;
                end else if (fmt == FMT_D && rs2_i == 5'd0) begin
                    op = OP_TO_D;
                end else begin
                    ill = 1'b1;
                end
            end
            OPF_MVX: begin
                to_int = 1'b1;
                if (rs2_i != 5'd0) ill = 1'b1;
                case (rm_i)
                    3'd0: begin
                        op = OP_MV_TOINT;
                        if (!fits) ill = 1'b1;
                    end
                    3'd1:    op = OP_CLASS;
                    default: ill = 1'b1;
                endcase
            end
            OPF_MVF: begin
                fp_wr = 1'b1;
                op    = OP_MV_FRINT;
                if (rs2_i != 5'd0 || rm_i != 3'd0 || !fits) ill = 1'b1;
            end
            default: ill = 1'b1;
        endcase

        if (fmt == 2'd2) ill = 1'b1;
        if (use_rnd && rm_bad) ill = 1'b1;

        dec_d.fmt     = fmt;
        dec_d.illegal = ill;
        if (ill) begin
            dec_d.op     = OP_NONE;
            dec_d.rm     = 3'd0;
            dec_d.to_int = 1'b0;
            dec_d.wen    = 1'b0;
            dec_d.dirty  = 1'b0;
        end else begin
            dec_d.op     = op;
            dec_d.rm     = use_rnd ? rm_eff : 3'd0;
            dec_d.to_int = to_int;
            dec_d.wen    = to_int ? (rd_i != 5'd0) : fp_wr;
            dec_d.dirty  = fp_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{op: OP_NONE, fmt: 2'd0, rm: 3'd0, to_int: 1'b0,
                       wen: 1'b0, dirty: 1'b0, illegal: 1'b0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign op_o       = dec_q.op;
    assign fmt_o      = dec_q.fmt;
    assign rm_o       = dec_q.rm;
    assign dst_int_o  = dec_q.to_int;
    assign wen_o      = dec_q.wen;
    assign fs_dirty_o = dec_q.dirty;
    assign illegal_o  = dec_q.illegal;

endmodule

// File: rtl/fp_op_decoder_chk.sv
module fp_op_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] funct7_i,
    input logic [2:0] rm_i,
    input logic [4:0] rd_i,
    input logic [4:0] op_o,
    input logic [2:0] rm_o,
    input logic       dst_int_o,
    input logic       wen_o,
    input logic       fs_dirty_o,
    input logic       illegal_o
);
    // R1: reserved precision seen at the previous edge gives illegal
    a_r1_fmt2_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(funct7_i[1:0]) == 2'd2) |-> illegal_o);

    // R3: reserved rounding mode on add gives illegal
    a_r3_reserved_rm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(funct7_i[6:2]) == 5'h00 &&
         ($past(rm_i) == 3'd5 || $past(rm_i) == 3'd6)) |-> illegal_o);

    // R3: a resolved rounding mode is never a reserved value
    a_r3_rm_range: assert property (@(posedge clk) disable iff (!rst_n)
        rm_o <= 3'd4);

    // R9: an integer write never targets index zero
    a_r9_rd0_int: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dst_int_o && wen_o) |-> $past(rd_i) != 5'd0);

    // R10: dirty strobe only with a floating-point write
    a_r10_dirty_fp: assert property (@(posedge clk) disable iff (!rst_n)
        fs_dirty_o |-> (wen_o && !dst_int_o));

    // R11: illegal suppresses everything
    a_r11_ill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wen_o && !fs_dirty_o && !dst_int_o && op_o == 5'd0));
endmodule

bind fp_op_decoder fp_op_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .funct7_i   (funct7_i),
    .rm_i       (rm_i),
    .rd_i       (rd_i),
    .op_o       (op_o),
    .rm_o       (rm_o),
    .dst_int_o  (dst_int_o),
    .wen_o      (wen_o),
    .fs_dirty_o (fs_dirty_o),
    .illegal_o  (illegal_o)
);

// File: tb/fp_op_decoder_bench.sv
module fp_op_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] funct7;
    logic [2:0] rm;
    logic [4:0] rs2;
    logic [4:0] rd;
    logic [2:0] dyn;

    logic [4:0] op_o, op_x;
    logic [1:0] fmt_o, fmt_x;
    logic [2:0] rm_o, rm_x;
    logic       int_o, int_x, wen_o, wen_x, dirty_o, dirty_x, ill_o, ill_x;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fp_op_decoder #(.XLEN(64)) u_fp_op_decoder (
        .clk(clk), .rst_n(rst_n), .funct7_i(funct7), .rm_i(rm), .rs2_i(rs2),
        .rd_i(rd), .dyn_rm_i(dyn), .op_o(op_o), .fmt_o(fmt_o), .rm_o(rm_o),
        .dst_int_o(int_o), .wen_o(wen_o), .fs_dirty_o(dirty_o), .illegal_o(ill_o)
    );

    fp_op_decoder #(.XLEN(32)) u_fp_op_decoder_x32 (
        .clk(clk), .rst_n(rst_n), .funct7_i(funct7), .rm_i(rm), .rs2_i(rs2),
        .rd_i(rd), .dyn_rm_i(dyn), .op_o(op_x), .fmt_o(fmt_x), .rm_o(rm_x),
        .dst_int_o(int_x), .wen_o(wen_x), .fs_dirty_o(dirty_x), .illegal_o(ill_x)
    );

    typedef struct packed {
        logic [6:0] f7;
        logic [2:0] rm;
        logic [4:0] rs2;
        logic [4:0] rd;
        logic [2:0] dyn;
        logic [4:0] eop;
        logic [2:0] erm;
        logic       eint;
        logic       ewen;
        logic       edirty;
        logic       eill;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t VEC [NV] = '{
        // f7     rm    rs2   rd    dyn   op     rm   int  wen  dty  ill  req
        '{7'h00, 3'd0, 5'd0, 5'd5, 3'd0, 5'd1,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 add
        '{7'h05, 3'd3, 5'd0, 5'd5, 3'd0, 5'd2,  3'd3, 1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 sub D
        '{7'h0B, 3'd4, 5'd0, 5'd5, 3'd0, 5'd3,  3'd4, 1'b0,1'b1,1'b1,1'b0, 4'd1},  // R1 quad mul
        '{7'h0C, 3'd1, 5'd0, 5'd5, 3'd0, 5'd4,  3'd1, 1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 div
        '{7'h0E, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd1},  // R1 fmt 2
        '{7'h00, 3'd5, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 rm5
        '{7'h01, 3'd6, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 rm6
        '{7'h00, 3'd7, 5'd0, 5'd5, 3'd2, 5'd1,  3'd2, 1'b0,1'b1,1'b1,1'b0, 4'd3},  // R3 dyn ok
        '{7'h00, 3'd7, 5'd0, 5'd5, 3'd7, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 dyn 7
        '{7'h04, 3'd7, 5'd0, 5'd5, 3'd5, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 dyn 5
        '{7'h2C, 3'd2, 5'd0, 5'd5, 3'd0, 5'd5,  3'd2, 1'b0,1'b1,1'b1,1'b0, 4'd4},  // R4 sqrt
        '{7'h2C, 3'd2, 5'd1, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4 rs2!=0
        '{7'h10, 3'd0, 5'd0, 5'd5, 3'd0, 5'd6,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd5},  // R5 sgn plain
        '{7'h11, 3'd1, 5'd0, 5'd5, 3'd0, 5'd7,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd5},  // R5 sgn neg
        '{7'h13, 3'd2, 5'd0, 5'd5, 3'd0, 5'd8,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd5},  // R5 sgn xor
        '{7'h10, 3'd3, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5 sgn bad
        '{7'h14, 3'd0, 5'd0, 5'd5, 3'd0, 5'd9,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd5},  // R5 min
        '{7'h15, 3'd1, 5'd0, 5'd5, 3'd0, 5'd10, 3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd5},  // R5 max
        '{7'h14, 3'd2, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5 minmax bad
        '{7'h50, 3'd0, 5'd0, 5'd5, 3'd0, 5'd11, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd9},  // R9 le
        '{7'h51, 3'd1, 5'd0, 5'd5, 3'd0, 5'd12, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd5},  // R5 lt
        '{7'h50, 3'd2, 5'd0, 5'd5, 3'd0, 5'd13, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd5},  // R5 eq
        '{7'h50, 3'd3, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5 cmp bad
        '{7'h50, 3'd2, 5'd0, 5'd0, 3'd0, 5'd13, 3'd0, 1'b1,1'b0,1'b0,1'b0, 4'd9},  // R9 rd0
        '{7'h60, 3'd1, 5'd0, 5'd5, 3'd0, 5'd14, 3'd1, 1'b1,1'b1,1'b0,1'b0, 4'd6},  // R6 f2i s32
        '{7'h61, 3'd1, 5'd3, 5'd5, 3'd0, 5'd17, 3'd1, 1'b1,1'b1,1'b0,1'b0, 4'd6},  // R6 f2i u64
        '{7'h60, 3'd1, 5'd4, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 rs2 4
        '{7'h60, 3'd0, 5'd1, 5'd0, 3'd0, 5'd15, 3'd0, 1'b1,1'b0,1'b0,1'b0, 4'd9},  // R9 rd0
        '{7'h68, 3'd0, 5'd1, 5'd5, 3'd0, 5'd19, 3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd6},  // R6 i2f u32
        '{7'h69, 3'd7, 5'd2, 5'd5, 3'd4, 5'd20, 3'd4, 1'b0,1'b1,1'b1,1'b0, 4'd6},  // R6 i2f s64
        '{7'h68, 3'd0, 5'd5, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 rs2 5
        '{7'h20, 3'd0, 5'd1, 5'd5, 3'd0, 5'd22, 3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd7},  // R7 to S
        '{7'h21, 3'd7, 5'd0, 5'd5, 3'd1, 5'd23, 3'd1, 1'b0,1'b1,1'b1,1'b0, 4'd7},  // R7 to D
        '{7'h20, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd7},  // R7 S from S
        '{7'h23, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd7},  // R7 quad
        '{7'h21, 3'd5, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 conv rm5
        '{7'h70, 3'd0, 5'd0, 5'd5, 3'd0, 5'd24, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd8},  // R8 mv to int
        '{7'h71, 3'd1, 5'd0, 5'd5, 3'd0, 5'd25, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd8},  // R8 class
        '{7'h73, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8 quad mv
        '{7'h73, 3'd1, 5'd0, 5'd5, 3'd0, 5'd25, 3'd0, 1'b1,1'b1,1'b0,1'b0, 4'd8},  // R8 quad class
        '{7'h70, 3'd1, 5'd1, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8 rs2
        '{7'h70, 3'd2, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8 rm2
        '{7'h78, 3'd0, 5'd0, 5'd5, 3'd0, 5'd26, 3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd8},  // R8 mv from int
        '{7'h78, 3'd1, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8 rm1
        '{7'h7B, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8 quad
        '{7'h18, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd2},  // R2 code 6
        '{7'h7C, 3'd0, 5'd0, 5'd5, 3'd0, 5'd0,  3'd0, 1'b0,1'b0,1'b0,1'b1, 4'd2},  // R2 code 0x1f
        '{7'h00, 3'd0, 5'd0, 5'd0, 3'd0, 5'd1,  3'd0, 1'b0,1'b1,1'b1,1'b0, 4'd10}  // R10 fp rd0
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] f, input logic [2:0] r, input logic [4:0] s,
                         input logic [4:0] d, input logic [2:0] y);
        funct7 = f; rm = r; rs2 = s; rd = d; dyn = y;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive(7'h0E, 3'd0, 5'd0, 5'd5, 3'd0);
        repeat (3) @(negedge clk);
        // R12: reset state, even with an illegal encoding applied
        check("R12", "reset illegal", int'(ill_o), 0);
        check("R12", "reset wen", int'(wen_o), 0);
        check("R12", "reset dirty", int'(dirty_o), 0);
        check("R12", "reset op", int'(op_o), 0);
        check("R12", "reset int", int'(int_o), 0);
        check("R12", "reset rm", int'(rm_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            string stag;
            drive(VEC[i].f7, VEC[i].rm, VEC[i].rs2, VEC[i].rd, VEC[i].dyn);
            @(negedge clk);
            tag  = $sformatf("R%0d", VEC[i].req);
            // strobes of illegal vectors belong to R11
            stag = VEC[i].eill ? "R11" : tag;
            check(tag,  "illegal", int'(ill_o), int'(VEC[i].eill));
            check(stag, "op (R13 code)", int'(op_o), int'(VEC[i].eop));
            check(tag,  "rm", int'(rm_o), int'(VEC[i].erm));
            check(stag, "dst_int", int'(int_o), int'(VEC[i].eint));
            check(stag, "wen", int'(wen_o), int'(VEC[i].ewen));
            check(stag, "dirty", int'(dirty_o), int'(VEC[i].edirty));
            check("R1", "fmt echo", int'(fmt_o), int'(VEC[i].f7[1:0]));
        end

        // R12: one-cycle latency; previous vector was legal add, apply illegal
        drive(7'h0E, 3'd0, 5'd0, 5'd5, 3'd0);
        #1;
        check("R12", "before edge illegal", int'(ill_o), 0);
        check("R12", "before edge op", int'(op_o), 1);
        @(negedge clk);
        check("R12", "after edge illegal", int'(ill_o), 1);

        // R6: 32-bit integer registers reject 64-bit types
        drive(7'h60, 3'd0, 5'd2, 5'd5, 3'd0);
        @(negedge clk);
        check("R6", "x32 f2i s64 illegal", int'(ill_x), 1);
        check("R6", "x64 f2i s64 legal", int'(ill_o), 0);
        drive(7'h68, 3'd0, 5'd1, 5'd5, 3'd0);
        @(negedge clk);
        check("R6", "x32 i2f u32 op", int'(op_x), 19);
        check("R6", "x32 i2f u32 legal", int'(ill_x), 0);

        // R8: raw move width against 32-bit integer registers
        drive(7'h70, 3'd0, 5'd0, 5'd5, 3'd0);
        @(negedge clk);
        check("R8", "x32 single mv legal", int'(ill_x), 0);
        check("R8", "x32 single mv op", int'(op_x), 24);
        drive(7'h71, 3'd0, 5'd0, 5'd5, 3'd0);
        @(negedge clk);
        check("R8", "x32 double mv illegal", int'(ill_x), 1);
        check("R8", "x64 double mv legal", int'(ill_o), 0);
        drive(7'h71, 3'd1, 5'd0, 5'd5, 3'd0);
        @(negedge clk);
        check("R8", "x32 double class legal", int'(op_x), 25);
        drive(7'h79, 3'd0, 5'd0, 5'd5, 3'd0);
        @(negedge clk);
        check("R8", "x32 double mv-from illegal", int'(ill_x), 1);
        check("R11", "x32 illegal no dirty", int'(dirty_x), 0);
        drive(7'h78, 3'd0, 5'd0, 5'd5, 3'd0);
        @(negedge clk);
        check("R10", "x32 single mv-from dirty", int'(dirty_x), 1);
        check("R3", "x32 rm zero", int'(rm_x), 0);
        check("R1", "x32 fmt", int'(fmt_x), 0);
        check("R9", "x32 int dest", int'(int_x), 0);
        check("R10", "x32 wen", int'(wen_x), 1);

        finish_run();
    end

endmodule